// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Sequencer

This block is the clocked core of a processor supply supervisor. An external threshold comparator supplies a supply-good flag. The processor drives a watchdog line, and a separate flag tells the block when that line is left floating. From these inputs the block produces one reset, driven on two pins of opposite polarity.

A low supply holds reset asserted for as long as it lasts. When the supply recovers, reset stays asserted for a further pulse width and is then released. Once reset is released, a watchdog counter runs. Any rising or falling edge on the watchdog line restarts it. If the counter expires, the block issues a reset of one pulse width, and a fresh watchdog interval begins only after that reset ends. A line held at one level therefore produces periodic resets, while a floating line turns the watchdog off.

All timing is given in clock cycles through parameters. Silicon uses values near 1.6 s for the timeout and 200 ms for the pulse width, and a bench can override both with short counts. Every asynchronous input passes through a synchronizer chain whose depth is a parameter.

Top module: `supv_rst_ctrl`

## Requirements
- R1: While the synchronized supply-good flag is low, reset is asserted on every cycle. After supply-good falls, reset asserts within SYNC_STAGES cycles.
- R2: After supply-good rises, reset stays asserted for exactly SYNC_STAGES + PULSE_CYC cycles, counted from the first clock edge after the rise, and is then released.
- R3: A rising or a falling edge on the synchronized watchdog input restarts the watchdog count from zero.
- R4: If the watchdog input has no edge for TIMEOUT_CYC released cycles, reset asserts for exactly PULSE_CYC cycles. An edge visible on the last of those cycles still counts as service.
- R5: The watchdog count is held at zero while reset is asserted. After a watchdog reset ends, a held input therefore gives exactly TIMEOUT_CYC released cycles before the next reset, for a period of TIMEOUT_CYC + PULSE_CYC.
- R6: While the floating flag is high, the watchdog never causes a reset.
- R7: rst_out_n is always the inverse of rst_out. rst_out = 1 means reset is asserted.
- R8: A watchdog input pulse one clock cycle wide counts as service.
- R9: If supply-good falls during a watchdog reset pulse, the supply-low condition wins. The stretch then restarts in full, lasting SYNC_STAGES + PULSE_CYC cycles after supply-good returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the logic itself |
| supply_ok | input | 1 | Supply above threshold, from external comparator (asynchronous) |
| wd_in | input | 1 | Watchdog service line from processor (asynchronous) |
| wd_float | input | 1 | High when the watchdog line is high-impedance (asynchronous) |
| rst_out_n | output | 1 | Reset to processor, active low |
| rst_out | output | 1 | Reset to processor, active high |

## Verification
The in-line properties check, on every cycle, that a low supply forces reset and that any watchdog edge clears the count. They also check that the count stays clear while reset is asserted, that a floating line never raises an expiry, that an expiry turns into a stretch, and that the two outputs stay complementary. Exact durations can only be shown by the bench's scenarios: the stretch length after power-up and after a brown-out, the released and asserted widths of periodic watchdog resets, and the sweep of service intervals up to and one past the timeout. The same applies to the single-cycle pulse and the restart of the stretch when the supply fails mid-pulse.

// File: rtl/supv_pkg.sv
package supv_pkg;
   typedef enum logic [1:0] {
      SUP_DOWN    = 2'd0,
      SUP_STRETCH = 2'd1,
      SUP_RUN     = 2'd2
   } sup_state_e;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("supv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
   parameter int TIMEOUT_CYC = 320_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wd_s,
   input  logic float_s,
   input  logic armed,
   output logic expire
);
   localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("supv_wdog: TIMEOUT_CYC must be at least 2");
   end

   logic          wd_prev;
   logic          edge_seen;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wd_prev <= 1'b0;
      else        wd_prev <= wd_s;
   end

   assign edge_seen = wd_s ^ wd_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt <= '0;
      else if (!armed || float_s || edge_seen) cnt <= '0;
      else if (cnt != LAST)                  cnt <= cnt + 1'b1;
   end

   assign expire = armed && !float_s && !edge_seen && (cnt == LAST);

   // R3: either edge restarts the count
   p_edge_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> (cnt == '0));
   // R5: count held cleared while reset is asserted
   p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> (cnt == '0));
   // R6: floating line never expires
   p_float_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      float_s |-> !expire);
endmodule

// File: rtl/supv_seq.sv
module supv_seq
   import supv_pkg::*;
#(
   parameter int PULSE_CYC = 40_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_s,
   input  logic expire,
   output logic armed,
   output logic rst_act
);
   localparam int HW = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;
   localparam logic [HW-1:0] HLAST = HW'(PULSE_CYC - 1);

   if (PULSE_CYC < 2) begin : g_bad_pulse
      $error("supv_seq: PULSE_CYC must be at least 2");
   end

   sup_state_e    state;
   logic [HW-1:0] hcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SUP_DOWN;
         hcnt  <= '0;
      end else if (!supply_s) begin
         state <= SUP_DOWN;
         hcnt  <= '0;
      end else begin
         unique case (state)
            SUP_DOWN: begin
               state <= SUP_STRETCH;
               hcnt  <= '0;
            end
            SUP_STRETCH: begin
               if (hcnt == HLAST) state <= SUP_RUN;
               else               hcnt  <= hcnt + 1'b1;
            end
            SUP_RUN: begin
               if (expire) begin
                  state <= SUP_STRETCH;
                  hcnt  <= '0;
               end
            end
            default: begin
               state <= SUP_DOWN;
               hcnt  <= '0;
            end
         endcase
      end
   end

   assign armed   = (state == SUP_RUN);
   assign rst_act = !armed;

   // R1: a low supply forces reset on the next cycle
   p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_s |=> rst_act);
   // R2: no early release during the stretch
   p_stretch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SUP_STRETCH && hcnt != HLAST) |=> rst_act);
   // R4: an expiry with the supply good starts a fresh stretch
   p_expire_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && supply_s) |=> (state == SUP_STRETCH && hcnt == '0));
endmodule

// File: rtl/supv_rst_ctrl.sv
module supv_rst_ctrl #(
   parameter int TIMEOUT_CYC = 320_000_000,
   parameter int PULSE_CYC   = 40_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic wd_in,
   input  logic wd_float,
   output logic rst_out_n,
   output logic rst_out
);
   logic supply_s, wd_s, float_s;
   logic armed, rst_act, expire;

   supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
      .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(supply_s));
   supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wd (
      .clk(clk), .rst_n(rst_n), .d(wd_in), .q(wd_s));
   supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_flt (
      .clk(clk), .rst_n(rst_n), .d(wd_float), .q(float_s));

   supv_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
      .clk(clk), .rst_n(rst_n), .wd_s(wd_s), .float_s(float_s),
      .armed(armed), .expire(expire));

   supv_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .supply_s(supply_s), .expire(expire),
      .armed(armed), .rst_act(rst_act));

   assign rst_out   = rst_act;
   assign rst_out_n = ~rst_act;

   // R7: the two reset pins stay complementary
   p_polarity_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out_n != rst_out);
endmodule

// File: tb/supv_rst_ctrl_test.sv
module supv_rst_ctrl_test;
   localparam int T = 40;
   localparam int P = 12;
   localparam int S = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic wd_in = 1'b0;
   logic wd_float = 1'b1;
   logic rst_out_n, rst_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   supv_rst_ctrl #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .SYNC_STAGES(S)) uut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_in(wd_in),
      .wd_float(wd_float), .rst_out_n(rst_out_n), .rst_out(rst_out));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_for(input logic lvl);
      int n = 0;
      while (rst_out !== lvl && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic count_level(input logic lvl, output int n);
      n = 0;
      while (rst_out === lvl && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // counts asserted-reset cycles over span negedges; also checks polarity (R7)
   task automatic run_cycles(input int span, output int highs, inout int polbad);
      highs = 0;
      for (int i = 0; i < span; i++) begin
         @(negedge clk);
         if (rst_out === 1'b1) highs++;
         if (rst_out_n !== ~rst_out) polbad++;
      end
   endtask

   initial begin
      int n, h, pb;
      int dlist [6];
      pb = 0;
      dlist = '{1, 2, 3, T/2, T-1, T};

      repeat (3) @(negedge clk);
      chk(rst_out === 1'b1, "R7 reset state rst_out", int'(rst_out), 1);
      chk(rst_out_n === 1'b0, "R7 reset state rst_out_n", int'(rst_out_n), 0);
      rst_n = 1'b1;

      // R1: supply low holds reset
      run_cycles(100, h, pb);
      chk(h == 100, "R1 reset held while supply low", h, 100);

      // R2: power-up stretch
      supply_ok = 1'b1;
      @(negedge clk);
      count_level(1'b1, n);
      chk(n == S + P, "R2 power-up stretch", n, S + P);

      // R6: floating line never resets
      run_cycles(3 * (T + P), h, pb);
      chk(h == 0, "R6 floating watchdog causes no reset", h, 0);

      // R4/R5: held input gives periodic resets
      wd_float = 1'b0;
      wait_for(1'b1);
      count_level(1'b1, n);
      chk(n == P, "R4 watchdog pulse width", n, P);
      count_level(1'b0, n);
      chk(n == T, "R5 full interval after watchdog pulse", n, T);
      count_level(1'b1, n);
      chk(n == P, "R4 second watchdog pulse width", n, P);

      // R3: sweep service intervals up to the timeout, now at release
      wd_in = ~wd_in;
      foreach (dlist[k]) begin
         int tot = 0;
         for (int j = 0; j < 4; j++) begin
            run_cycles(dlist[k], h, pb);
            tot += h;
            wd_in = ~wd_in;
         end
         chk(tot == 0, "R3 service interval keeps reset released", tot, 0);
      end
      // R4 boundary: one past the timeout expires
      run_cycles(T + 1, h, pb);
      chk(h == 0, "R4 no reset before expiry", h, 0);
      wait_for(1'b1);

      // R9: supply drops during a watchdog pulse
      repeat (3) @(negedge clk);
      supply_ok = 1'b0;
      run_cycles(20, h, pb);
      chk(h == 20, "R9 reset held while supply low mid-pulse", h, 20);
      supply_ok = 1'b1;
      @(negedge clk);
      count_level(1'b1, n);
      chk(n == S + P, "R9 full stretch after supply returns", n, S + P);

      // R8: one-cycle pulse services the watchdog
      repeat (T - 5) @(negedge clk);
      wd_in = ~wd_in;
      @(negedge clk);
      wd_in = ~wd_in;
      count_level(1'b0, n);
      chk(n == T + S + 1, "R8 single-cycle pulse restarts count", n, T + S + 1);

      // R1: brown-out while released
      wait_for(1'b0);
      supply_ok = 1'b0;
      @(negedge clk);
      count_level(1'b0, n);
      chk(n == S, "R1 brown-out latency", n, S);
      run_cycles(30, h, pb);
      chk(h == 30, "R1 reset held after brown-out", h, 30);

      chk(pb == 0, "R7 outputs complementary throughout", pb, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule